// File: doc/BRIEF.md
# Audio Serial Word Formatter

This block is the transmit half of an audio serial link. Software or a DMA engine hands it 32-bit register values over a valid/ready handshake. The block splits each value into one, two or four audio words, depending on the configured word length. It then shifts each word onto a serial data line, one bit per bit-clock falling edge, inside a slot that is 16 or 32 bit clocks wide. The bit-clock falling edges arrive as a single-cycle enable, `bit_tick`, in the system clock domain. A word-select line marks alternate slots as even (low) and odd (high).

Slot bits that carry no data are padding. The padding level and whether padding comes before or after the data are both selectable. For word lengths that leave part of the register unused, an alignment input chooses the upper or the lower end of the register. When the producer falls behind, the block repeats the last word and raises a sticky underflow flag. A combination in which the word does not fit the slot is reported, and every slot is then sent as padding.

Control is a three-state machine:
- `ST_IDLE` waits for the first register value. On an accepted value it moves to `ST_RUN`.
- `ST_RUN` sends words. At each slot end it takes one of three paths:
  - it moves to the next packed word and stays in `ST_RUN`;
  - it loads a pending or same-cycle register and stays in `ST_RUN`;
  - with nothing pending after the last word, it moves to `ST_STARVE`.
- `ST_STARVE` resends the last word. At a slot end it returns to `ST_RUN` once a register is available, and otherwise stays.

Top module: `aud_tx_formatter`

## Requirements
- R1: Every non-data bit of a slot equals `cfg_pad_hi` (0 drives low, 1 drives high).
- R2: With `cfg_pad_first`=0 a slot carries the word bits and then the padding; with `cfg_pad_first`=1 it carries the padding and then the word bits, so the word's last bit is the slot's last bit.
- R3: Words are sent most significant bit first. `cfg_wlen` codes are 0=8, 1=16, 2=18, 3=20, 4=22, 5=24 and 6=32 bits; code 7 is invalid. For codes 2 to 5, `cfg_right_align`=0 takes the word from the top bits of the register and `cfg_right_align`=1 takes it from the bottom bits.
- R4: `cfg_right_align` has no effect for codes 0, 1 and 6, nor while `cfg_packed` is 1; in those cases a 18 to 24-bit word is taken from the top bits.
- R5: At code 0 one register supplies four words, in the order bits 7:0, 15:8, 23:16, 31:24.
- R6: At code 1 one register supplies two words, bits 15:0 first and then bits 31:16.
- R7: `ws_out` is low through even slots and high through odd slots, counting from slot 0 after the first load. It takes the new slot's level at the tick that sends the last bit of the previous slot.
- R8: `in_ready` is 1 in `ST_IDLE`. Otherwise it is 1 only while the last packed word of the current register is being sent and no further value is pending. An accepted value replaces the register at the next slot start.
- R9: If no register value is available when a slot starts after the last packed word, `underflow` goes to 1 at that tick and stays there until reset, and the last word is sent again.
- R10: `cfg_err` is 1 when `cfg_wlen` is 7 or the word is longer than the slot (16 bits when `cfg_slot32`=0, else 32); every slot bit is then padding.
- R11: After reset `sd_out`=0, `ws_out`=0, `in_ready`=1 and `underflow`=0; `sd_out` and `ws_out` change only at edges where `bit_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle enable at each bit-clock falling edge |
| cfg_wlen | input | 3 | Word length code |
| cfg_slot32 | input | 1 | Slot width: 0 = 16 bits, 1 = 32 bits |
| cfg_pad_hi | input | 1 | Padding level |
| cfg_pad_first | input | 1 | Padding before data in the slot |
| cfg_right_align | input | 1 | Take partial-width words from the register's low end |
| cfg_packed | input | 1 | Packed-channel mode; overrides the alignment input |
| in_data | input | 32 | Register value to send |
| in_valid | input | 1 | Register value offered |
| in_ready | output | 1 | Register value can be accepted |
| sd_out | output | 1 | Serial data |
| ws_out | output | 1 | Word select |
| underflow | output | 1 | Sticky: a slot started with no new data |
| cfg_err | output | 1 | Word length and slot width do not fit together |

## Verification
A wrong word index or a missed register swap shows up on `sd_out` within the slot that follows. If the register is swapped early, the handshake opens too soon and `in_ready` shows it within one clock. A bit counter that is off by one moves every data bit and shifts the word-select edge in the first slot. A state that enters `ST_STARVE` on the wrong slot sets `underflow` one slot early or late, and because the flag is sticky the error stays visible until reset.

// File: rtl/aud_fmt_pkg.sv
package aud_fmt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_STARVE = 2'd2
    } fmt_state_e;

    localparam logic [2:0] WL_8  = 3'd0;
    localparam logic [2:0] WL_16 = 3'd1;
    localparam logic [2:0] WL_32 = 3'd6;

    // word length in bits for a length code, 0 for the unused code
    function automatic int word_bits(input logic [2:0] code);
        case (code)
            3'd0:    return 8;
            3'd1:    return 16;
            3'd2:    return 18;
            3'd3:    return 20;
            3'd4:    return 22;
            3'd5:    return 24;
            3'd6:    return 32;
            default: return 0;
        endcase
    endfunction

    // how many audio words one register value carries
    function automatic int words_per_reg(input logic [2:0] code);
        case (code)
            WL_8:    return 4;
            WL_16:   return 2;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/aud_fmt_word_pick.sv
module aud_fmt_word_pick
    import aud_fmt_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int LEN_W = 6
) (
    input  logic [REG_W-1:0] reg_word,
    input  logic [1:0]       idx,
    input  logic [2:0]       wlen,
    input  logic [LEN_W-1:0] wbits,
    input  logic             right_align,
    input  logic             packed_mode,
    output logic [REG_W-1:0] word_o
);
    localparam int NB = REG_W / 8;
    localparam int NH = REG_W / 16;

    logic [7:0]       lane8  [NB];
    logic [15:0]      lane16 [NH];
    logic             use_low;
    logic [REG_W-1:0] low_mask;

    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_byte
            assign lane8[g] = reg_word[8*g +: 8];
        end
        for (g = 0; g < NH; g++) begin : g_half
            assign lane16[g] = reg_word[16*g +: 16];
        end
    endgenerate

    assign use_low  = right_align && !packed_mode;
    assign low_mask = ({{(REG_W-1){1'b0}}, 1'b1} << wbits) - 1'b1;

    always_comb begin
        unique case (wlen)
            WL_8:    word_o = REG_W'(lane8[idx]);
            WL_16:   word_o = REG_W'(lane16[idx[0]]);
            WL_32:   word_o = reg_word;
            default: word_o = use_low ? (reg_word & low_mask)
                                      : (reg_word >> (REG_W - int'(wbits)));
        endcase
    end
endmodule

// File: rtl/aud_fmt_slot_bit.sv
module aud_fmt_slot_bit #(
    parameter int REG_W = 32,
    parameter int CNT_W = 5,
    parameter int LEN_W = 6
) (
    input  logic [REG_W-1:0] word,
    input  logic [LEN_W-1:0] wbits,
    input  logic [LEN_W-1:0] sbits,
    input  logic [CNT_W-1:0] pos,
    input  logic             pad_hi,
    input  logic             pad_first,
    input  logic             invalid,
    output logic             bit_o
);
    localparam int IDX_W = $clog2(REG_W);

    logic [LEN_W-1:0] p;
    logic [LEN_W-1:0] pads;
    logic [IDX_W-1:0] di;

    assign p    = LEN_W'(pos);
    assign pads = sbits - wbits;

    always_comb begin
        bit_o = pad_hi;
        di    = '0;
        if (!invalid) begin
            if (!pad_first) begin
                if (p < wbits) begin
                    di    = IDX_W'(wbits - 1'b1 - p);
                    bit_o = word[di];
                end
            end else if (p >= pads) begin
                di    = IDX_W'(sbits - 1'b1 - p);
                bit_o = word[di];
            end
        end
    end
endmodule

// File: rtl/aud_tx_formatter.sv
module aud_tx_formatter
    import aud_fmt_pkg::*;
#(
    parameter int REG_W      = 32,
    parameter int SLOT_SHORT = 16,
    parameter int SLOT_LONG  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic [2:0]       cfg_wlen,
    input  logic             cfg_slot32,
    input  logic             cfg_pad_hi,
    input  logic             cfg_pad_first,
    input  logic             cfg_right_align,
    input  logic             cfg_packed,
    input  logic [REG_W-1:0] in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             sd_out,
    output logic             ws_out,
    output logic             underflow,
    output logic             cfg_err
);
    localparam int CNT_W = $clog2(SLOT_LONG);
    localparam int LEN_W = CNT_W + 1;

    fmt_state_e       st, st_nx;
    logic [CNT_W-1:0] cnt;
    logic             par;
    logic [REG_W-1:0] hold, nbuf, cur_word;
    logic             nfull;
    logic [1:0]       widx, last_idx;
    logic [LEN_W-1:0] wbits, sbits;
    logic             slot_end, more_words, take, fetch, bit_now;

    assign wbits      = LEN_W'(word_bits(cfg_wlen));
    assign sbits      = cfg_slot32 ? LEN_W'(SLOT_LONG) : LEN_W'(SLOT_SHORT);
    assign last_idx   = 2'(words_per_reg(cfg_wlen) - 1);
    assign cfg_err    = (wbits == '0) || (wbits > sbits);
    assign slot_end   = ({1'b0, cnt} >= (sbits - 1'b1));
    assign more_words = (widx < last_idx);
    assign take       = in_valid && in_ready;
    assign fetch      = nfull || take;

    always_comb begin
        unique case (st)
            ST_IDLE: in_ready = 1'b1;
            default: in_ready = (widx >= last_idx) && !nfull;
        endcase
    end

    aud_fmt_word_pick #(.REG_W(REG_W), .LEN_W(LEN_W)) u_pick (
        .reg_word    (hold),
        .idx         (widx),
        .wlen        (cfg_wlen),
        .wbits       (wbits),
        .right_align (cfg_right_align),
        .packed_mode (cfg_packed),
        .word_o      (cur_word)
    );

    aud_fmt_slot_bit #(.REG_W(REG_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_bit (
        .word      (cur_word),
        .wbits     (wbits),
        .sbits     (sbits),
        .pos       (cnt),
        .pad_hi    (cfg_pad_hi),
        .pad_first (cfg_pad_first),
        .invalid   (cfg_err),
        .bit_o     (bit_now)
    );

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (take) st_nx = ST_RUN;
            ST_RUN, ST_STARVE:
                if (bit_tick && slot_end && !more_words)
                    st_nx = fetch ? ST_RUN : ST_STARVE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // slot position, word index and register buffers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            par   <= 1'b0;
            hold  <= '0;
            nbuf  <= '0;
            nfull <= 1'b0;
            widx  <= '0;
        end else if (st == ST_IDLE) begin
            cnt   <= '0;
            par   <= 1'b0;
            widx  <= '0;
            nfull <= 1'b0;
            if (take) hold <= in_data;
        end else begin
            if (take) begin
                nbuf  <= in_data;
                nfull <= 1'b1;
            end
            if (bit_tick) begin
                if (slot_end) begin
                    cnt <= '0;
                    par <= ~par;
                    if (more_words) begin
                        widx <= widx + 2'd1;
                    end else if (fetch) begin
                        hold  <= nfull ? nbuf : in_data;
                        widx  <= '0;
                        nfull <= 1'b0;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // serial outputs and the sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_out    <= 1'b0;
            ws_out    <= 1'b0;
            underflow <= 1'b0;
        end else if (bit_tick) begin
            if (st == ST_IDLE) begin
                sd_out <= cfg_pad_hi;
            end else begin
                sd_out <= bit_now;
                ws_out <= slot_end ? ~par : par;
                if (slot_end && !more_words && !fetch) underflow <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/aud_tx_formatter_chk.sv
module aud_tx_formatter_chk
    import aud_fmt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bit_tick,
    input logic       cfg_pad_hi,
    input logic       cfg_err,
    input logic       in_valid,
    input logic       in_ready,
    input logic       sd_out,
    input logic       ws_out,
    input logic       underflow,
    input fmt_state_e st
);
    // R11: serial lines move only with a bit tick
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(sd_out) && $stable(ws_out));

    // R9: the flag never clears by itself
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    // R9: the flag rises only at a bit tick
    a_r9_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> $past(bit_tick));

    // R10: a misfit slot carries only padding
    a_r10_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && cfg_err) |=> (sd_out == $past(cfg_pad_hi)));

    // R8: at most one value waits behind the current register
    a_r8_one_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !bit_tick && st != ST_IDLE) |=> !in_ready);
endmodule

bind aud_tx_formatter aud_tx_formatter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .cfg_pad_hi (cfg_pad_hi),
    .cfg_err    (cfg_err),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .sd_out     (sd_out),
    .ws_out     (ws_out),
    .underflow  (underflow),
    .st         (st)
);

// File: tb/aud_tx_formatter_test.sv
module aud_tx_formatter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic [2:0]  cfg_wlen = '0;
    logic        cfg_slot32 = 1'b0, cfg_pad_hi = 1'b0, cfg_pad_first = 1'b0;
    logic        cfg_right_align = 1'b0, cfg_packed = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready, sd_out, ws_out, underflow, cfg_err;

    always #5 clk = ~clk;

    aud_tx_formatter uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cfg_wlen(cfg_wlen),
        .cfg_slot32(cfg_slot32), .cfg_pad_hi(cfg_pad_hi), .cfg_pad_first(cfg_pad_first),
        .cfg_right_align(cfg_right_align), .cfg_packed(cfg_packed), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .sd_out(sd_out), .ws_out(ws_out),
        .underflow(underflow), .cfg_err(cfg_err)
    );

    int n_run = 0, n_fail = 0, quiet_bad = 0;
    logic [31:0] regs [2];
    int nregs = 0, ptr = 0, bitn = 0;
    logic sd_cap [512];
    logic ws_cap [512];

    // {wlen, slot32, pad_hi, pad_first, right_align, packed, reg0, reg1}
    localparam bit [71:0] VEC [9] = '{
        {3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hA5C31E78, 32'h0F963CE1},
        {3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h80017FFE, 32'h1234C0DE},
        {3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'hDEADBEEF, 32'h5A5A0F0F},
        {3'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 32'hF00DCAFE, 32'h01234567},
        {3'd5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 32'h89ABCDEF, 32'h76543210},
        {3'd6, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'hC001D00D, 32'h3C3CA5A5},
        {3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'hBEEF1234, 32'h00FFFF00},
        {3'd6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFF0000, 32'h13579BDF},
        {3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h2468ACE0, 32'hFEDCBA98}
    };

    function automatic string vtag(input int v);
        case (v)
            0: return "R5 R1 R2";
            1: return "R6 R2 R1";
            2: return "R3";
            3: return "R3 R2";
            4: return "R4";
            5: return "R4 R3";
            6: return "R4 R6";
            7: return "R10";
            default: return "R3 R2";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int bw(input logic [2:0] c);
        case (c)
            3'd0: return 8;  3'd1: return 16; 3'd2: return 18; 3'd3: return 20;
            3'd4: return 22; 3'd5: return 24; 3'd6: return 32; default: return 0;
        endcase
    endfunction

    function automatic int nwords();
        return (cfg_wlen == 3'd0) ? 4 : (cfg_wlen == 3'd1) ? 2 : 1;
    endfunction

    function automatic int slot_w();
        return cfg_slot32 ? 32 : 16;
    endfunction

    function automatic logic exp_sd(input int s, input int k);
        int W, S, nw, total, g, wi;
        logic [31:0] r, w;
        W = bw(cfg_wlen); S = slot_w(); nw = nwords(); total = nw * nregs;
        if (W == 0 || W > S) return cfg_pad_hi;
        g = (s < total) ? s : total - 1;
        r = regs[g / nw]; wi = g % nw;
        if (W == 8)       w = (r >> (8 * wi)) & 32'hFF;
        else if (W == 16) w = (r >> (16 * wi)) & 32'hFFFF;
        else if (W == 32) w = r;
        else if (cfg_right_align && !cfg_packed) w = r & ((32'h1 << W) - 1);
        else w = r >> (32 - W);
        if (!cfg_pad_first) return (k < W) ? w[W-1-k] : cfg_pad_hi;
        return (k < S - W) ? cfg_pad_hi : w[S-1-k];
    endfunction

    // one system clock; a tick step records the serial outputs after the edge
    task automatic step(input logic t);
        logic hs;
        bit_tick = t;
        in_valid = (ptr < nregs);
        in_data  = (ptr < nregs) ? regs[ptr] : 32'h0;
        #1;
        hs = in_valid && in_ready;
        @(posedge clk);
        if (hs) ptr++;
        @(negedge clk);
        if (t) begin
            sd_cap[bitn] = sd_out;
            ws_cap[bitn] = ws_out;
            bitn++;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bit_tick = 1'b0; in_valid = 1'b0;
        nregs = 0; ptr = 0; bitn = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_vec(input int v);
        bit [71:0] e;
        int S, total, nbits, bad_sd, bad_ws, first_sd, first_ws;
        logic hold_sd;
        e = VEC[v];
        do_reset();
        {cfg_wlen, cfg_slot32, cfg_pad_hi, cfg_pad_first, cfg_right_align, cfg_packed} = e[71:64];
        regs[0] = e[63:32]; regs[1] = e[31:0]; nregs = 2;
        S = slot_w(); total = nwords() * nregs; nbits = (total + 1) * S;
        step(1'b0);
        for (int i = 0; i < nbits; i++) begin
            step(1'b1);
            hold_sd = sd_out;
            if (i == total * S - 2)
                chk(underflow == 1'b0, {"R9 no early flag ", vtag(v)}, 32'(underflow), 0);
            step(1'b0); step(1'b0); step(1'b0);
            if (sd_out !== hold_sd) quiet_bad++;
        end
        bad_sd = 0; bad_ws = 0; first_sd = -1; first_ws = -1;
        for (int i = 0; i < nbits; i++) begin
            int s, k;
            logic ews;
            s = i / S; k = i % S;
            ews = (k == S - 1) ? ~s[0] : s[0];
            if (sd_cap[i] !== exp_sd(s, k)) begin bad_sd++; if (first_sd < 0) first_sd = i; end
            if (ws_cap[i] !== ews) begin bad_ws++; if (first_ws < 0) first_ws = i; end
        end
        chk(bad_sd == 0, {"serial data ", vtag(v)}, 32'(bad_sd), 0);
        if (first_sd >= 0)
            $display("  vec %0d first data mismatch at bit %0d: actual %0b expected %0b",
                     v, first_sd, sd_cap[first_sd], exp_sd(first_sd / S, first_sd % S));
        chk(bad_ws == 0, "R7 word select", 32'(bad_ws), 0);
        if (first_ws >= 0) $display("  vec %0d first word-select mismatch at bit %0d", v, first_ws);
        chk(underflow == 1'b1, "R9 flag after starving slot", 32'(underflow), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R11 reset state
        do_reset();
        #1;
        chk(sd_out == 1'b0 && ws_out == 1'b0, "R11 serial lines after reset", {30'b0, sd_out, ws_out}, 0);
        chk(in_ready == 1'b1 && underflow == 1'b0, "R11 ready and flag after reset",
            {30'b0, in_ready, underflow}, 32'h2);

        for (int v = 0; v < 9; v++) run_vec(v);
        chk(quiet_bad == 0, "R11 outputs held between ticks", 32'(quiet_bad), 0);

        // R8 handshake opens only in the last slot of a register
        do_reset();
        cfg_wlen = 3'd0; cfg_slot32 = 1'b0; cfg_pad_hi = 1'b0; cfg_pad_first = 1'b0;
        cfg_right_align = 1'b0; cfg_packed = 1'b0;
        regs[0] = 32'h11223344; nregs = 1;
        step(1'b0);
        chk(ptr == 1, "R8 idle accepts", 32'(ptr), 1);
        #1;
        chk(in_ready == 1'b0, "R8 ready low in first slot", 32'(in_ready), 0);
        for (int i = 0; i < 3 * 16 - 1; i++) begin
            step(1'b1); step(1'b0);
        end
        #1;
        chk(in_ready == 1'b0, "R8 ready low before last slot", 32'(in_ready), 0);
        step(1'b1);
        #1;
        chk(in_ready == 1'b1, "R8 ready high in last slot", 32'(in_ready), 1);

        // R10 combination flag
        cfg_wlen = 3'd6; cfg_slot32 = 1'b0; #1;
        chk(cfg_err == 1'b1, "R10 32-bit word in 16-bit slot", 32'(cfg_err), 1);
        cfg_wlen = 3'd7; cfg_slot32 = 1'b1; #1;
        chk(cfg_err == 1'b1, "R10 unused length code", 32'(cfg_err), 1);
        cfg_wlen = 3'd5; cfg_slot32 = 1'b0; #1;
        chk(cfg_err == 1'b1, "R10 24-bit word in 16-bit slot", 32'(cfg_err), 1);
        cfg_wlen = 3'd1; cfg_slot32 = 1'b0; #1;
        chk(cfg_err == 1'b0, "R10 16-bit word in 16-bit slot", 32'(cfg_err), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule